// File: doc/BRIEF.md
# Sleep Mode Control Unit

This block decides when an exception-driven core may stop its clock and when it must start again. Software asks for sleep in three ways. A wait-for-interrupt strobe always sleeps. A wait-for-event strobe sleeps unless an event has already been recorded. With the sleep-on-exit control bit set, the final return from a handler to base level also leads straight into sleep. On that last path the block tells the core to skip unstacking the interrupted context, because only a new exception can end the sleep and that exception would stack the same context again.

While the core sleeps, the block holds the core clock enable low. If the deep-sleep control bit is set, it also raises a request that lets system-level logic gate clocks beyond the core. A pending exception of sufficient priority ends the sleep on the next clock edge. In the same cycle that the exception is seen, the deep-sleep request is withdrawn, so it always drops before the core clock comes back. The block drives request and enable signals only. The gating cells and power switches belong to the surrounding logic.

Top module: `lowpwr_seq`

## Requirements
- R1: After reset the core is awake: `core_sleep_o`=0, `core_clk_en_o`=1, `sys_deep_req_o`=0, `skip_restore_o`=0, and no event is recorded.
- R2: When awake, a `wfi_req_i` pulse with `exc_pending_i`=0 sets `core_sleep_o`=1 and `core_clk_en_o`=0 from the next clock edge.
- R3: When awake and no event is recorded, a `wfe_req_i` pulse sleeps exactly as in R2. If an event is recorded, the pulse does not sleep and it clears the record, so a second `wfe_req_i` pulse then sleeps.
- R4: An `event_i` pulse records an event, at any time. The record stays until a `wfe_req_i` pulse consumes it.
- R5: When awake, an `exc_return_i` pulse with `return_to_base_i`=1, `sleep_on_exit_i`=1 and `exc_pending_i`=0 enters sleep with `skip_restore_o`=1. If either of the two qualifiers is 0, the return does not sleep.
- R6: While asleep with `exc_pending_i`=0, the core stays asleep. Any `wfi_req_i`, `wfe_req_i` or `exc_return_i` pulse has no effect.
- R7: While asleep, `exc_pending_i`=1 wakes the core at the next edge: `core_sleep_o`=0, `core_clk_en_o`=1 and `skip_restore_o`=0.
- R8: `sys_deep_req_o` is 1 only while asleep with `deep_en_i`=1 and `exc_pending_i`=0. It falls in the same cycle that `exc_pending_i` rises, one edge before `core_clk_en_o` returns to 1.
- R9: A sleep request of any kind that arrives while `exc_pending_i`=1 does not sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wfi_req_i | input | 1 | Wait-for-interrupt strobe, one cycle |
| wfe_req_i | input | 1 | Wait-for-event strobe, one cycle |
| event_i | input | 1 | Event pulse that is recorded for a later wait-for-event |
| sleep_on_exit_i | input | 1 | Control bit: sleep on the final return to base level |
| deep_en_i | input | 1 | Control bit: ask for system-wide clock gating while asleep |
| exc_pending_i | input | 1 | An exception of sufficient priority is pending |
| exc_return_i | input | 1 | Exception-return strobe, one cycle |
| return_to_base_i | input | 1 | The current return leaves the last active handler |
| core_sleep_o | output | 1 | Core is in the sleep state |
| core_clk_en_o | output | 1 | Enable for the core clock gate |
| sys_deep_req_o | output | 1 | Deep-sleep request to system clock control |
| skip_restore_o | output | 1 | Sleep was entered on exit; the core must not unstack its context |

## Verification
The bench targets how a wait-for-event behaves with a recorded event. A design that ignores the record would sleep at once. A design that never clears it would refuse every later wait-for-event. The bench also checks the sleep-on-exit qualifiers one at a time, because a design that decodes only one of them would sleep on a nested return. It raises a pending exception in the same cycle as each kind of sleep request, where a design without the pending check would enter a sleep that nothing is left to end. Finally, it samples the deep-sleep request in the cycle the wake-up starts, where a design that registers the request would still hold it while the core clock restarts.

// File: rtl/lowpwr_seq.sv
module lowpwr_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic wfi_req_i,
  input  logic wfe_req_i,
  input  logic event_i,
  input  logic sleep_on_exit_i,
  input  logic deep_en_i,
  input  logic exc_pending_i,
  input  logic exc_return_i,
  input  logic return_to_base_i,
  output logic core_sleep_o,
  output logic core_clk_en_o,
  output logic sys_deep_req_o,
  output logic skip_restore_o
);

  logic asleep_q, via_exit_q, evt_q;
  logic wfe_sleeps, exit_sleeps, enter, wfe_consume;

  assign wfe_sleeps  = wfe_req_i & ~evt_q;
  assign exit_sleeps = exc_return_i & return_to_base_i & sleep_on_exit_i;
  assign enter       = ~asleep_q & ~exc_pending_i & (wfi_req_i | wfe_sleeps | exit_sleeps);
  assign wfe_consume = ~asleep_q & wfe_req_i & evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep_q   <= 1'b0;
      via_exit_q <= 1'b0;
    end else if (asleep_q) begin
      if (exc_pending_i) begin
        asleep_q   <= 1'b0;
        via_exit_q <= 1'b0;
      end
    end else if (enter) begin
      asleep_q   <= 1'b1;
      via_exit_q <= exit_sleeps & ~wfi_req_i & ~wfe_sleeps;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= event_i | (evt_q & ~wfe_consume);
  end

  assign core_sleep_o   = asleep_q;
  assign core_clk_en_o  = ~asleep_q;
  assign sys_deep_req_o = asleep_q & deep_en_i & ~exc_pending_i;
  assign skip_restore_o = asleep_q & via_exit_q;

  assert_wfi_sleeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep_q && wfi_req_i && !exc_pending_i) |=> (core_sleep_o && !core_clk_en_o));

  assert_wfe_event_skips_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep_q && wfe_req_i && evt_q && !wfi_req_i && !exit_sleeps) |=> !core_sleep_o);

  assert_exit_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep_q && exit_sleeps && !wfi_req_i && !wfe_sleeps && !exc_pending_i) |=> skip_restore_o);

  assert_hold_sleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_sleep_o && !exc_pending_i) |=> core_sleep_o);

  assert_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_sleep_o && exc_pending_i) |=> (core_clk_en_o && !skip_restore_o));

  assert_deep_before_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en_o) |-> !$past(sys_deep_req_o));

  assert_no_entry_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_sleep_o && exc_pending_i) |=> !core_sleep_o);

endmodule

// File: tb/lowpwr_seq_bench.sv
module lowpwr_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wfi, wfe, evt, soe, deep, pend, eret, base;
  logic sleep_o, clk_en_o, deep_o, skip_o;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  lowpwr_seq u_lowpwr_seq (
    .clk(clk), .rst_n(rst_n), .wfi_req_i(wfi), .wfe_req_i(wfe), .event_i(evt),
    .sleep_on_exit_i(soe), .deep_en_i(deep), .exc_pending_i(pend),
    .exc_return_i(eret), .return_to_base_i(base),
    .core_sleep_o(sleep_o), .core_clk_en_o(clk_en_o),
    .sys_deep_req_o(deep_o), .skip_restore_o(skip_o));

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wake();
    pend = 1'b1; step(); pend = 1'b0; step();
  endtask

  task automatic t_reset();
    chk("R1 sleep", sleep_o, 1'b0);
    chk("R1 clk_en", clk_en_o, 1'b1);
    chk("R1 deep", deep_o, 1'b0);
    chk("R1 skip", skip_o, 1'b0);
  endtask

  task automatic t_wfi_hold_wake();
    wfi = 1'b1; step(); wfi = 1'b0;
    chk("R2 sleep", sleep_o, 1'b1);
    chk("R2 clk_en", clk_en_o, 1'b0);
    chk("R2 skip", skip_o, 1'b0);
    wfi = 1'b1; step(); wfi = 1'b0;
    wfe = 1'b1; step(); wfe = 1'b0;
    soe = 1'b1; base = 1'b1; eret = 1'b1; step(); eret = 1'b0; soe = 1'b0; base = 1'b0;
    step();
    chk("R6 still asleep", sleep_o, 1'b1);
    chk("R6 clk still off", clk_en_o, 1'b0);
    chk("R6 skip unchanged", skip_o, 1'b0);
    pend = 1'b1; step(); pend = 1'b0;
    chk("R7 awake", sleep_o, 1'b0);
    chk("R7 clk_en", clk_en_o, 1'b1);
  endtask

  task automatic t_wfe();
    wfe = 1'b1; step(); wfe = 1'b0;
    chk("R3 wfe sleeps without event", sleep_o, 1'b1);
    wake();
    evt = 1'b1; step(); evt = 1'b0;
    step(); step();
    wfe = 1'b1; step(); wfe = 1'b0;
    chk("R4 R3 wfe with recorded event stays awake", sleep_o, 1'b0);
    step();
    wfe = 1'b1; step(); wfe = 1'b0;
    chk("R3 event consumed, second wfe sleeps", sleep_o, 1'b1);
    evt = 1'b1; step(); evt = 1'b0;
    wake();
    wfe = 1'b1; step(); wfe = 1'b0;
    chk("R4 event recorded while asleep", sleep_o, 1'b0);
    step();
  endtask

  task automatic t_exit();
    eret = 1'b1; base = 1'b1; soe = 1'b0; step(); eret = 1'b0;
    chk("R5 no sleep without control bit", sleep_o, 1'b0);
    eret = 1'b1; base = 1'b0; soe = 1'b1; step(); eret = 1'b0;
    chk("R5 no sleep on nested return", sleep_o, 1'b0);
    eret = 1'b1; base = 1'b1; soe = 1'b1; step(); eret = 1'b0; base = 1'b0;
    chk("R5 sleep on exit", sleep_o, 1'b1);
    chk("R5 skip restore", skip_o, 1'b1);
    pend = 1'b1; step(); pend = 1'b0; soe = 1'b0;
    chk("R7 skip cleared on wake", skip_o, 1'b0);
    chk("R7 awake after exit sleep", clk_en_o, 1'b1);
    step();
  endtask

  task automatic t_deep();
    deep = 1'b1; step();
    chk("R8 no deep request while awake", deep_o, 1'b0);
    wfi = 1'b1; step(); wfi = 1'b0;
    chk("R8 deep request while asleep", deep_o, 1'b1);
    pend = 1'b1; #1;
    chk("R8 deep released on pending", deep_o, 1'b0);
    chk("R8 clock still off", clk_en_o, 1'b0);
    step(); pend = 1'b0;
    chk("R8 clock restored", clk_en_o, 1'b1);
    chk("R8 deep stays low when awake", deep_o, 1'b0);
    deep = 1'b0; step();
    wfi = 1'b1; step(); wfi = 1'b0;
    chk("R8 no deep request with bit clear", deep_o, 1'b0);
    wake();
  endtask

  task automatic t_collide();
    pend = 1'b1; wfi = 1'b1; step(); wfi = 1'b0;
    chk("R9 wfi with pending", sleep_o, 1'b0);
    wfe = 1'b1; step(); wfe = 1'b0;
    chk("R9 wfe with pending", sleep_o, 1'b0);
    soe = 1'b1; base = 1'b1; eret = 1'b1; step(); eret = 1'b0; base = 1'b0; soe = 1'b0;
    chk("R9 exit with pending", sleep_o, 1'b0);
    pend = 1'b0; step();
  endtask

  initial begin
    wfi = 0; wfe = 0; evt = 0; soe = 0; deep = 0; pend = 0; eret = 0; base = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_wfi_hold_wake();
    t_wfe();
    t_exit();
    t_deep();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule